// File: doc/BRIEF.md
# Memory-Mapped Interrupt Status Reporter

This block turns interrupt events from hardware units into byte writes to a memory region, so that a host can learn about interrupts by reading memory instead of status registers. Each unit raises a 16-bit event vector together with its unit index and the index of the engine instance it belongs to. For every enabled, asserted event bit the block writes the marker value 0xFF to a byte of its own in the unit's 16-byte slot of a status area. It then writes a 0xFF flag byte for the unit into a source area, and finally pulses a host interrupt.

The region is made of 4 KiB pages. The page number is programmed, so every page is 4 KiB aligned. In each page the status area begins at offset 0x000 and gives unit `u` the bytes `u*16 .. u*16+15`, where byte `u*16+b` stands for event bit `b`. The source area begins at offset 0x400 and gives unit `u` the byte at `0x400+u`. In per-instance mode the instance index selects the page that follows the programmed one by that many pages. In shared mode every instance uses the programmed page. A 16-bit enable mask is ANDed with each event vector before it is reported.

Events are handled one at a time, in the order they arrive. The base page, the mode and the enable mask are taken when an event is accepted, so the configuration cannot change partway through a report.

Top module: `irq_mem_reporter`

## Requirements
- R1: For an accepted event, every bit `b` that is set in both `evt_vec` and `cfg_enable` produces exactly one write of data 0xFF at address `page + unit*16 + b`. No write is made for any other bit.
- R2: The status writes of one event are issued in strictly ascending bit order.
- R3: After the last status write of an event is accepted, exactly one write of data 0xFF follows at address `page + 0x400 + unit`. It is the last write of the event.
- R4: `irq_pulse` is high for exactly one cycle per reported event: the cycle right after the handshake of the source write. It is low at all other times.
- R5: If `evt_vec & cfg_enable` is zero, the event is still consumed (`evt_ready` high), but no memory write and no interrupt follow.
- R6: When `cfg_per_inst` is 1, `page = (cfg_page + evt_inst) * 4096`. When it is 0, `page = cfg_page * 4096` whatever `evt_inst` is.
- R7: `evt_ready` is low while a report is in progress, that is, whenever `mem_valid` is high. Events are reported in the order they were accepted, and one event's writes never interleave with another's.
- R8: `cfg_page`, `cfg_per_inst` and `cfg_enable` are sampled at the cycle an event is accepted. Changing them during a report has no effect on that report.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_addr` stays unchanged on the next cycle.
- R10: After reset, `evt_ready` is 1 and `mem_valid` and `irq_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event request valid |
| evt_ready | output | 1 | Event can be accepted (idle) |
| evt_unit | input | UNIT_W (6) | Index of the unit raising the event |
| evt_inst | input | INST_W (3) | Engine instance index of the event |
| evt_vec | input | VEC_W (16) | Event bit vector |
| cfg_page | input | ADDR_W-12 (20) | Base page number (address divided by 4096) |
| cfg_per_inst | input | 1 | 1: each instance uses its own page; 0: all instances share the base page |
| cfg_enable | input | VEC_W (16) | Event enable mask |
| mem_valid | output | 1 | Byte write request valid |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W (32) | Byte address of the write |
| mem_data | output | 8 | Byte written (always 0xFF) |
| irq_pulse | output | 1 | One-cycle host interrupt |

## Verification
The bench goes through all 64 unit slots and all eight instances in both modes, and compares every write address, in order, with arithmetic built from the layout. A design that got the slot or instance offset wrong would write into a neighbour's slot or page, and a design that ignored the mode would show the wrong page. Enable masks are swept, including a mask that removes every set bit. A design that skipped the mask would write disabled bytes, and one that did not drop empty events would raise an interrupt with only a source flag behind it. Configuration is changed in the middle of a report, and a second event is queued behind a busy one, under random back-pressure. A design that re-read its configuration live, or that accepted events while busy, would mix pages or interleave writes. Finally, the interrupt cycle is compared with the cycle of the last write, which catches an interrupt that fires before the source flag has landed.

// File: rtl/irq_rpt_pkg.sv
package irq_rpt_pkg;

  // Offset layout inside one 4 KiB page
  localparam int PAGE_SHIFT = 12;
  localparam logic [PAGE_SHIFT-1:0] SRC_OFS = 12'h400;
  localparam logic [7:0] MARK_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STATUS = 2'd1,
    ST_SOURCE = 2'd2
  } rpt_state_e;

endpackage

// File: rtl/irq_rpt_lowbit.sv
// Finds the lowest set bit of a vector: one-hot form and binary index.
module irq_rpt_lowbit #(
  parameter int W = 16,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [W-1:0]     first,
  output logic [IDX_W-1:0] idx
);

  logic [W-1:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 1; i < W; i++) begin : g_below
    assign below[i] = below[i-1] | vec[i-1];
  end

  assign first = vec & ~below;

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_rpt_addr.sv
// Byte address generator for status slots and source flags.
module irq_rpt_addr
  import irq_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int UNIT_W = 6,
  parameter int INST_W = 3,
  parameter int BIT_W  = 4,
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [INST_W-1:0] inst,
  input  logic              per_inst,
  input  logic [UNIT_W-1:0] unit,
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic              is_source,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0]     page_base;
  logic [ADDR_W-1:0]     inst_step;
  logic [PAGE_SHIFT-1:0] status_ofs;
  logic [PAGE_SHIFT-1:0] source_ofs;
  logic [PAGE_SHIFT-1:0] ofs;

  assign page_base  = {page, {PAGE_SHIFT{1'b0}}};
  assign inst_step  = per_inst ? ADDR_W'({inst, {PAGE_SHIFT{1'b0}}}) : '0;
  assign status_ofs = {{(PAGE_SHIFT-UNIT_W-BIT_W){1'b0}}, unit, bit_idx};
  assign source_ofs = SRC_OFS | {{(PAGE_SHIFT-UNIT_W){1'b0}}, unit};
  assign ofs        = is_source ? source_ofs : status_ofs;
  assign addr       = page_base + inst_step + ADDR_W'(ofs);

endmodule

// File: rtl/irq_rpt_ctrl.sv
// Report sequencer: accepts an event, walks its enabled bits, writes the
// source flag and raises the interrupt.
module irq_rpt_ctrl
  import irq_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int UNIT_W = 6,
  parameter int INST_W = 3,
  parameter int VEC_W  = 16,
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [UNIT_W-1:0] evt_unit,
  input  logic [INST_W-1:0] evt_inst,
  input  logic [VEC_W-1:0]  evt_vec,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              cfg_per_inst,
  input  logic [VEC_W-1:0]  cfg_enable,
  input  logic              mem_ready,
  input  logic [VEC_W-1:0]  low_onehot,
  output logic              mem_valid,
  output logic              is_source,
  output logic [VEC_W-1:0]  pend_q,
  output logic [UNIT_W-1:0] unit_q,
  output logic [INST_W-1:0] inst_q,
  output logic [PAGE_W-1:0] page_q,
  output logic              mode_q,
  output logic              irq_q
);

  rpt_state_e       state_q, state_d;
  logic [VEC_W-1:0] pend_d;
  logic [VEC_W-1:0] masked;
  logic             load_en;
  logic             pend_en;
  logic             irq_d;
  logic             wr_hs;

  assign masked = evt_vec & cfg_enable;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    load_en   = 1'b0;
    pend_en   = 1'b0;
    irq_d     = 1'b0;
    evt_ready = (state_q == ST_IDLE);
    mem_valid = (state_q != ST_IDLE);
    is_source = (state_q == ST_SOURCE);
    wr_hs     = mem_valid && mem_ready;
    unique case (state_q)
      ST_IDLE: begin
        if (evt_valid) begin
          load_en = 1'b1;
          pend_en = 1'b1;
          pend_d  = masked;
          if (masked != '0) state_d = ST_STATUS;
        end
      end
      ST_STATUS: begin
        if (wr_hs) begin
          pend_en = 1'b1;
          pend_d  = pend_q & ~low_onehot;
          if (pend_d == '0) state_d = ST_SOURCE;
        end
      end
      ST_SOURCE: begin
        if (wr_hs) begin
          state_d = ST_IDLE;
          irq_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
      pend_q  <= '0;
      unit_q  <= '0;
      inst_q  <= '0;
      page_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      if (pend_en) pend_q <= pend_d;
      if (load_en) begin
        unit_q <= evt_unit;
        inst_q <= evt_inst;
        page_q <= cfg_page;
        mode_q <= cfg_per_inst;
      end
    end
  end

  AST_STATUS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STATUS) |-> (pend_q != '0)); // R1

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && $past(mem_valid)) |-> ($stable(page_q) && $stable(mode_q) && $stable(unit_q))); // R8

endmodule

// File: rtl/irq_mem_reporter.sv
// Top: memory-mapped interrupt status reporter.
module irq_mem_reporter
  import irq_rpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int UNIT_W = 6,
  parameter int INST_W = 3,
  parameter int VEC_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       evt_valid,
  output logic                       evt_ready,
  input  logic [UNIT_W-1:0]          evt_unit,
  input  logic [INST_W-1:0]          evt_inst,
  input  logic [VEC_W-1:0]           evt_vec,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] cfg_page,
  input  logic                       cfg_per_inst,
  input  logic [VEC_W-1:0]           cfg_enable,
  output logic                       mem_valid,
  input  logic                       mem_ready,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [7:0]                 mem_data,
  output logic                       irq_pulse
);

  localparam int BIT_W  = $clog2(VEC_W);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  logic [VEC_W-1:0]  pend_q;
  logic [VEC_W-1:0]  low_onehot;
  logic [BIT_W-1:0]  low_idx;
  logic [UNIT_W-1:0] unit_q;
  logic [INST_W-1:0] inst_q;
  logic [PAGE_W-1:0] page_q;
  logic              mode_q;
  logic              is_source;

  irq_rpt_ctrl #(
    .ADDR_W(ADDR_W), .UNIT_W(UNIT_W), .INST_W(INST_W), .VEC_W(VEC_W)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_valid   (evt_valid),
    .evt_ready   (evt_ready),
    .evt_unit    (evt_unit),
    .evt_inst    (evt_inst),
    .evt_vec     (evt_vec),
    .cfg_page    (cfg_page),
    .cfg_per_inst(cfg_per_inst),
    .cfg_enable  (cfg_enable),
    .mem_ready   (mem_ready),
    .low_onehot  (low_onehot),
    .mem_valid   (mem_valid),
    .is_source   (is_source),
    .pend_q      (pend_q),
    .unit_q      (unit_q),
    .inst_q      (inst_q),
    .page_q      (page_q),
    .mode_q      (mode_q),
    .irq_q       (irq_pulse)
  );

  irq_rpt_lowbit #(.W(VEC_W)) i_lowbit (
    .vec  (pend_q),
    .first(low_onehot),
    .idx  (low_idx)
  );

  irq_rpt_addr #(
    .ADDR_W(ADDR_W), .UNIT_W(UNIT_W), .INST_W(INST_W), .BIT_W(BIT_W)
  ) i_addr (
    .page     (page_q),
    .inst     (inst_q),
    .per_inst (mode_q),
    .unit     (unit_q),
    .bit_idx  (low_idx),
    .is_source(is_source),
    .addr     (mem_addr)
  );

  assign mem_data = MARK_BYTE;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R9

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !evt_ready); // R7

  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(mem_valid && mem_ready && is_source)); // R4

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R4

  AST_STATUS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !is_source && $past(mem_valid && mem_ready && !is_source))
      |-> (mem_addr > $past(mem_addr))); // R2

  AST_SRC_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid && is_source) |-> $past(mem_valid && mem_ready)); // R3

  AST_SRC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && is_source) |-> (mem_addr[PAGE_SHIFT-1:0] >= SRC_OFS &&
      mem_addr[PAGE_SHIFT-1:0] < (SRC_OFS + 12'h040))); // R3

  AST_MASKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready && ((evt_vec & cfg_enable) == '0))
      |=> (!mem_valid && !irq_pulse)); // R5

endmodule

// File: tb/test_irq_mem_reporter.sv
module test_irq_mem_reporter;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int UNIT_W = 6;
  localparam int INST_W = 3;
  localparam int VEC_W  = 16;
  localparam int PAGE_W = ADDR_W - 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              evt_valid;
  logic              evt_ready;
  logic [UNIT_W-1:0] evt_unit;
  logic [INST_W-1:0] evt_inst;
  logic [VEC_W-1:0]  evt_vec;
  logic [PAGE_W-1:0] cfg_page;
  logic              cfg_per_inst;
  logic [VEC_W-1:0]  cfg_enable;
  logic              mem_valid;
  logic              mem_ready;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_data;
  logic              irq_pulse;

  irq_mem_reporter i_irq_mem_reporter (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_unit(evt_unit), .evt_inst(evt_inst), .evt_vec(evt_vec),
    .cfg_page(cfg_page), .cfg_per_inst(cfg_per_inst), .cfg_enable(cfg_enable),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .irq_pulse(irq_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  logic [ADDR_W-1:0] log_addr [0:63];
  logic [7:0]        log_data [0:63];
  int                log_cyc  [0:63];
  int                log_n = 0;
  int                irq_n = 0;
  int                irq_cyc [0:3];
  logic [ADDR_W-1:0] exp_addr [0:63];
  int                exp_n = 0;
  int                hold_viol = 0;
  int                busy_viol = 0;
  logic              prev_stall = 1'b0;
  logic [ADDR_W-1:0] prev_addr = '0;
  logic              bp_en = 1'b0;
  logic [15:0]       lfsr = 16'hACE1;

  // monitor: sample outputs just before each rising edge takes effect
  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_ready && log_n < 64) begin
        log_addr[log_n] = mem_addr;
        log_data[log_n] = mem_data;
        log_cyc[log_n]  = cyc;
        log_n++;
      end
      if (irq_pulse) begin
        if (irq_n < 4) irq_cyc[irq_n] = cyc;
        irq_n++;
      end
      if (prev_stall && !(mem_valid && mem_addr == prev_addr)) hold_viol++;
      if (mem_valid && evt_ready) busy_viol++;
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
    end
    cyc++;
    if (cyc > 150000) begin
      checks++; bad++;
      $display("FAIL watchdog: cycle=%0d expected completion before 150000", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= bp_en ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  function automatic logic [ADDR_W-1:0] page_of(input logic [PAGE_W-1:0] pg,
                                               input logic md, input int inst);
    longint p;
    p = md ? (longint'(pg) + inst) : longint'(pg);
    return ADDR_W'(p * 4096);
  endfunction

  // expected writes from R1/R3/R6
  task automatic add_exp(input int u, input int inst, input logic [15:0] v,
                         input logic [15:0] en, input logic md,
                         input logic [PAGE_W-1:0] pg);
    logic [ADDR_W-1:0] base;
    base = page_of(pg, md, inst);
    if ((v & en) != 0) begin
      for (int b = 0; b < 16; b++)
        if (v[b] && en[b]) begin
          exp_addr[exp_n] = base + ADDR_W'(u * 16 + b);
          exp_n++;
        end
      exp_addr[exp_n] = base + ADDR_W'(32'h400 + u);
      exp_n++;
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    log_n = 0; irq_n = 0; exp_n = 0;
  endtask

  task automatic send(input int u, input int inst, input logic [15:0] v);
    @(negedge clk);
    evt_unit = UNIT_W'(u); evt_inst = INST_W'(inst); evt_vec = v;
    evt_valid = 1'b1;
    #1;
    while (!evt_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic wait_irq(input int n);
    int t = 0;
    while (irq_n < n && t < 600) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_seq(input string tag, input int n_irq);
    logic ok;
    int mis;
    ok = (log_n == exp_n) && (irq_n == n_irq);
    mis = -1;
    for (int k = 0; k < 64; k++)
      if (k < log_n && k < exp_n && mis < 0 &&
          (log_addr[k] != exp_addr[k] || log_data[k] != 8'hFF)) mis = k;
    if (mis >= 0) ok = 1'b0;
    if (ok && n_irq == 1 && log_n > 0 && irq_cyc[0] != log_cyc[log_n-1] + 1) ok = 1'b0;
    checks++;
    if (!ok) begin
      bad++;
      if (mis >= 0)
        $display("FAIL %s: write %0d addr=%h data=%h expected addr=%h data=ff",
                 tag, mis, log_addr[mis], log_data[mis], exp_addr[mis]);
      else
        $display("FAIL %s: writes=%0d irqs=%0d expected writes=%0d irqs=%0d (irq timing)",
                 tag, log_n, irq_n, exp_n, n_irq);
    end
  endtask

  task automatic one_event(input string tag, input int u, input int inst,
                           input logic [15:0] v);
    clear_logs();
    add_exp(u, inst, v, cfg_enable, cfg_per_inst, cfg_page);
    send(u, inst, v);
    if (exp_n > 0) wait_irq(1); else repeat (20) @(negedge clk);
    check_seq(tag, exp_n > 0 ? 1 : 0);
  endtask

  initial begin
    rst_n = 1'b0;
    evt_valid = 1'b0; evt_unit = '0; evt_inst = '0; evt_vec = '0;
    cfg_page = 20'h12345; cfg_per_inst = 1'b0; cfg_enable = 16'hFFFF;
    mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (!(evt_ready === 1'b1 && mem_valid === 1'b0 && irq_pulse === 1'b0)) begin
      bad++;
      $display("FAIL R10: ready=%b valid=%b irq=%b expected 1 0 0",
               evt_ready, mem_valid, irq_pulse);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4 R6(shared): all unit slots, instance ignored, back-pressure
    bp_en = 1'b1;
    for (int u = 0; u < 64; u++)
      one_event("R1_R2_R3_R4_R6 unit sweep shared", u, u % 8,
                16'(16'h0001 << (u % 16)) | 16'(16'h8000 >> (u / 4)) | 16'(u * 97));

    // R6 per-instance pages
    cfg_per_inst = 1'b1;
    for (int i = 0; i < 8; i++)
      one_event("R6 per-instance page", 5 + i, i, 16'hA5C3);
    cfg_per_inst = 1'b0;

    // R1 boundaries: all bits, lowest, highest
    one_event("R1 all bits", 63, 7, 16'hFFFF);
    one_event("R1 bit0", 0, 0, 16'h0001);
    one_event("R1 bit15", 62, 3, 16'h8000);

    // R5 enable mask sweep, including full removal
    for (int k = 0; k < 16; k++) begin
      cfg_enable = 16'(16'hFFFF >> k) ^ 16'(k * 16'h0101);
      one_event("R5 mask sweep", k, 1, 16'hFFFF ^ 16'(k << 3));
    end
    cfg_enable = 16'hFF0F;
    one_event("R5 fully masked", 9, 2, 16'h00F0);
    cfg_enable = 16'h0000;
    one_event("R5 all disabled", 10, 0, 16'hFFFF);
    cfg_enable = 16'hFFFF;

    // R8 configuration changed mid-report
    clear_logs();
    cfg_page = 20'h00ABC; cfg_per_inst = 1'b1; cfg_enable = 16'h0F0F;
    add_exp(33, 6, 16'hFFFF, 16'h0F0F, 1'b1, 20'h00ABC);
    send(33, 6, 16'hFFFF);
    cfg_page = 20'h77777; cfg_per_inst = 1'b0; cfg_enable = 16'hFFFF;
    wait_irq(1);
    check_seq("R8 config change during report", 1);

    // R7 second event queued behind a busy report
    clear_logs();
    cfg_page = 20'h00010; cfg_per_inst = 1'b1;
    add_exp(12, 1, 16'h0F00, 16'hFFFF, 1'b1, 20'h00010);
    add_exp(40, 2, 16'h0003, 16'hFFFF, 1'b1, 20'h00010);
    send(12, 1, 16'h0F00);
    send(40, 2, 16'h0003);
    wait_irq(2);
    check_seq("R7 back-to-back ordering", 2);
    checks++;
    if (busy_viol != 0) begin
      bad++;
      $display("FAIL R7: ready-while-busy cycles=%0d expected 0", busy_viol);
    end
    checks++;
    if (hold_viol != 0) begin
      bad++;
      $display("FAIL R9: stalled request changed %0d times expected 0", hold_viol);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule